// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the phase engine of a direct digital synthesizer. On every master clock edge it adds one of two frequency tuning words to a phase accumulator. It then adds one of four phase offsets to the top bits of the accumulator. The result is a phase word for a downstream sine lookup. The output frequency is the tuning word times the master clock rate, divided by 2^ACC_W. The offset counts span one full cycle over 2^PH_W steps.

A command decoder upstream feeds the tuning words, offsets and select fields. It also writes a small control word that holds three bits: sleep, reset and clear. Select changes can take effect at once, or through a two-stage resynchronizer when synchronous switching is wanted.

Top module: `nco_core`

## Requirements
- R1: After rst_ni is released, valid_o and phase_o are 0. The control word starts with sleep, reset and clear all set. The output therefore stays invalid, and the accumulator stays at 0, until an enable command is written.
- R2: While running, the accumulator advances by the selected tuning word on every clock. phase_o shows the top PH_W accumulator bits plus the selected offset, with one register of delay, and valid_o is 1.
- R3: The accumulator wraps modulo 2^ACC_W. The phase sum wraps modulo 2^PH_W.
- R4: The frequency select (freq_sel_i) picks word k from freq_words_i bits [k*ACC_W +: ACC_W].
- R5: The 2-bit phase select (phase_sel_i) picks offset k from phase_offs_i bits [k*PH_W +: PH_W].
- R6: A control write with ctl_op_i=1 (enable) clears sleep, reset and clear together. The write takes effect from the next clock.
- R7: A control write with ctl_op_i=2 (disable) sets reset and leaves sleep and clear unchanged. ctl_op_i=3 clears reset only. ctl_op_i=0 loads ctl_bits_i, where bit 2 is sleep, bit 1 is reset and bit 0 is clear.
- R8: While reset is set, the accumulator is held at 0 and valid_o is 0.
- R9: While sleep is set (and reset is not), the accumulator is frozen and valid_o is 0. Running resumes from the frozen value.
- R10: While clear is set, both effective selects are 0 and both resynchronizer stages are flushed to 0.
- R11: With sync_i high, a select change reaches the datapath two clocks after it is presented.
- R12: With sync_i low, a select change applies on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_words_i | input | N_FREQ*ACC_W | Packed frequency tuning words |
| phase_offs_i | input | N_PHASE*PH_W | Packed phase offsets |
| freq_sel_i | input | FSEL_W | Frequency word select |
| phase_sel_i | input | PSEL_W | Phase offset select |
| sync_i | input | 1 | Route selects through the two-stage resynchronizer |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_op_i | input | 2 | Control operation: 0 load, 1 enable, 2 disable, 3 release reset |
| ctl_bits_i | input | 3 | Load value {sleep, reset, clear} |
| phase_o | output | PH_W | Phase word |
| valid_o | output | 1 | Phase word is valid |

## Verification
The bench targets the following corner cases, and shows what a faulty design would do in each:

- **Wrap of the accumulator.** A tuning word near full scale forces the accumulator to wrap every cycle. A carry leaking into a wider accumulator would drift the phase.
- **Wrap of the phase sum.** An offset of 0xFFF makes the phase sum wrap. A saturating adder would stick at the top value.
- **Synchronous switching.** The bench turns synchronous mode on with stale stages and changes the selects. A design with one stage, or one that ignores the stages, applies the new word a cycle early.
- **Clear, disable and sleep.** The bench asserts clear with nonzero selects presented, then releases it with sync on; an unflushed stage would leak an old select. It issues disable while clear is set, then releases reset; a disable that also dropped clear would switch to the wrong tuning word. It enters and leaves sleep; a design that reset instead of freezing would restart the phase at 0.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic sleep;
    logic rst;
    logic clr;
  } nco_ctl_t;

  typedef enum logic [1:0] {
    CTL_LOAD    = 2'd0,
    CTL_ENABLE  = 2'd1,
    CTL_DISABLE = 2'd2,
    CTL_RELEASE = 2'd3
  } ctl_op_e;

  localparam nco_ctl_t CTL_POWERUP = '{sleep: 1'b1, rst: 1'b1, clr: 1'b1};
endpackage

// File: rtl/nco_ctl.sv
module nco_ctl
  import nco_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] op_i,
  input  logic [2:0] bits_i,
  output nco_ctl_t   ctl_o
);
  nco_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_POWERUP;
    end else if (we_i) begin
      unique case (ctl_op_e'(op_i))
        CTL_LOAD:    ctl_q <= nco_ctl_t'(bits_i);
        CTL_ENABLE:  ctl_q <= '0;
        CTL_DISABLE: ctl_q.rst <= 1'b1;
        CTL_RELEASE: ctl_q.rst <= 1'b0;
        default:     ctl_q <= ctl_q;
      endcase
    end
  end

  assign ctl_o = ctl_q;

  p_enable_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == CTL_ENABLE) |=> (ctl_o == '0));

  p_disable_reset_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == CTL_DISABLE) |=> (ctl_o.rst && $stable(ctl_o.sleep) && $stable(ctl_o.clr)));

  p_release_reset_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == CTL_RELEASE) |=> (!ctl_o.rst && $stable(ctl_o.sleep) && $stable(ctl_o.clr)));
endmodule

// File: rtl/nco_sel_sync.sv
module nco_sel_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sel_i,
  input  logic         sync_i,
  input  logic         clear_i,
  output logic [W-1:0] sel_o
);
  localparam int STAGES = 2;

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (clear_i) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= sel_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  always_comb begin
    if (clear_i)     sel_o = '0;
    else if (sync_i) sel_o = stg_q[STAGES-1];
    else             sel_o = sel_i;
  end

  // cycles since reset, saturating, guards $past depth
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_sync_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && sync_i && !clear_i && !$past(clear_i) && !$past(clear_i, 2))
      |-> (sel_o == $past(sel_i, 2)));

  p_flush_after_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && $past(clear_i) && !clear_i && sync_i) |-> (sel_o == '0));
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  poff_i,
  input  logic             sleep_i,
  input  logic             hold_rst_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (hold_rst_i) begin
      acc_q <= '0;
    end else if (!sleep_i) begin
      acc_q <= acc_q + ftw_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      valid_q <= 1'b0;
    end else begin
      phase_q <= acc_q[ACC_W-1 -: PH_W] + poff_i;
      valid_q <= !sleep_i && !hold_rst_i;
    end
  end

  assign phase_o = phase_q;
  assign valid_o = valid_q;

  p_reset_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |=> (acc_q == '0 && !valid_o));

  p_sleep_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !hold_rst_i) |=> $stable(acc_q));

  p_sleep_invalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !valid_o);
endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4,
  localparam int FSEL_W = $clog2(N_FREQ),
  localparam int PSEL_W = $clog2(N_PHASE)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_FREQ*ACC_W-1:0]   freq_words_i,
  input  logic [N_PHASE*PH_W-1:0]   phase_offs_i,
  input  logic [FSEL_W-1:0]         freq_sel_i,
  input  logic [PSEL_W-1:0]         phase_sel_i,
  input  logic                      sync_i,
  input  logic                      ctl_we_i,
  input  logic [1:0]                ctl_op_i,
  input  logic [2:0]                ctl_bits_i,
  output logic [PH_W-1:0]           phase_o,
  output logic                      valid_o
);
  nco_ctl_t          ctl;
  logic [FSEL_W-1:0] fsel_eff;
  logic [PSEL_W-1:0] psel_eff;
  logic [ACC_W-1:0]  ftw;
  logic [PH_W-1:0]   poff;

  nco_ctl i_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we_i),
    .op_i   (ctl_op_i),
    .bits_i (ctl_bits_i),
    .ctl_o  (ctl)
  );

  nco_sel_sync #(.W(FSEL_W)) i_fsel_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (freq_sel_i),
    .sync_i  (sync_i),
    .clear_i (ctl.clr),
    .sel_o   (fsel_eff)
  );

  nco_sel_sync #(.W(PSEL_W)) i_psel_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (phase_sel_i),
    .sync_i  (sync_i),
    .clear_i (ctl.clr),
    .sel_o   (psel_eff)
  );

  assign ftw  = freq_words_i[fsel_eff*ACC_W +: ACC_W];
  assign poff = phase_offs_i[psel_eff*PH_W +: PH_W];

  nco_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) i_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ftw_i      (ftw),
    .poff_i     (poff),
    .sleep_i    (ctl.sleep),
    .hold_rst_i (ctl.rst),
    .phase_o    (phase_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/test_nco_core.sv
module test_nco_core;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 32;
  localparam int PH_W  = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ACC_W-1:0] fw [2];
  logic [PH_W-1:0]  po [4];
  logic       fsel = 1'b0;
  logic [1:0] psel = 2'd0;
  logic       sync = 1'b0;
  logic       we = 1'b0;
  logic [1:0] op = 2'd0;
  logic [2:0] bits = 3'd0;
  logic [PH_W-1:0] phase;
  logic valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_core i_nco_core (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .freq_words_i ({fw[1], fw[0]}),
    .phase_offs_i ({po[3], po[2], po[1], po[0]}),
    .freq_sel_i   (fsel),
    .phase_sel_i  (psel),
    .sync_i       (sync),
    .ctl_we_i     (we),
    .ctl_op_i     (op),
    .ctl_bits_i   (bits),
    .phase_o      (phase),
    .valid_o      (valid)
  );

  typedef struct {
    logic            v;
    logic [PH_W-1:0] ph;
    string           tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic m_sleep = 1, m_rst = 1, m_clr = 1;
  logic m_f1 = 0, m_f2 = 0;
  logic [1:0] m_p1 = 0, m_p2 = 0;
  logic [ACC_W-1:0] m_acc = '0;

  task automatic step(input string tag);
    exp_t e;
    logic fe;
    logic [1:0] pe;
    fe = m_clr ? 1'b0 : (sync ? m_f2 : fsel);
    pe = m_clr ? 2'd0 : (sync ? m_p2 : psel);
    e.v   = !m_sleep && !m_rst;
    e.ph  = m_acc[ACC_W-1 -: PH_W] + po[pe];
    e.tag = tag;
    q.push_back(e);
    if (m_rst)         m_acc = '0;
    else if (!m_sleep) m_acc = m_acc + fw[fe];
    if (m_clr) begin
      m_f2 = 0; m_f1 = 0; m_p2 = 0; m_p1 = 0;
    end else begin
      m_f2 = m_f1; m_f1 = fsel; m_p2 = m_p1; m_p1 = psel;
    end
    if (we) begin
      case (op)
        2'd0: {m_sleep, m_rst, m_clr} = bits;
        2'd1: {m_sleep, m_rst, m_clr} = 3'b000;
        2'd2: m_rst = 1'b1;
        default: m_rst = 1'b0;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [1:0] o, input logic [2:0] b, input string tag);
    we = 1'b1; op = o; bits = b;
    step(tag);
    we = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (valid !== e.v || (e.v && phase !== e.ph) || (!e.v && phase !== e.ph)) begin
        failures++;
        $display("FAIL %s: valid=%0b phase=%h expected valid=%0b phase=%h",
                 e.tag, valid, phase, e.v, e.ph);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fw[0] = 32'h1000_0000;
    fw[1] = 32'hF000_0001;
    po[0] = 12'h100; po[1] = 12'h7FF; po[2] = 12'hC00; po[3] = 12'hFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    checks++;
    if (valid !== 1'b0 || phase !== '0) begin
      failures++;
      $display("FAIL R1: valid=%0b phase=%h expected valid=0 phase=000", valid, phase);
    end
    run(3, "R1");
    ctl_write(2'd1, 3'b000, "R6");
    run(8, "R2");
    psel = 2'd1; run(3, "R12");
    psel = 2'd3; run(3, "R5");
    fsel = 1'b1; run(4, "R4");
    run(16, "R3");
    sync = 1'b1; psel = 2'd2; fsel = 1'b0;
    run(4, "R11");
    psel = 2'd1; fsel = 1'b1;
    run(4, "R11");
    fsel = 1'b1; psel = 2'd3;
    ctl_write(2'd0, 3'b001, "R10");
    run(4, "R10");
    ctl_write(2'd0, 3'b000, "R10");
    run(4, "R10");
    ctl_write(2'd0, 3'b001, "R10");
    ctl_write(2'd2, 3'b000, "R7");
    run(3, "R8");
    ctl_write(2'd3, 3'b000, "R7");
    run(4, "R7");
    ctl_write(2'd0, 3'b100, "R9");
    run(4, "R9");
    ctl_write(2'd0, 3'b000, "R9");
    run(4, "R9");
    sync = 1'b0;
    run(3, "R2");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule